// File: doc/BRIEF.md
# Silicon Strip Hit Clusterer

This block turns hit streams from silicon strip sensor readouts into clusters. It accepts one hit at a time per input channel, in rising strip order. A hit is a strip address and a raw ADC sample. Each channel has its own per-strip calibration memory with three fields: a bad-strip flag, a pedestal and a gain factor. Before grouping, each hit is looked up in that memory. A flagged strip is dropped. Otherwise the pedestal is subtracted, the gain is applied, and a hit whose corrected charge comes out as zero is discarded. The same logic works for axial and stereo strip planes.

Surviving hits on consecutive strips are collected into a cluster, up to a fixed width. A sequential divider then reduces each cluster to a charge-weighted centroid in quarter-strip units, which is passed on with the summed charge. An end-of-event marker on the input closes any cluster still being built. The marker then appears on the output after that cluster. The default build has eight independent channels, and all of them share a single calibration write port.

Top module: `strip_clusterer`

## Requirements
- R1: A hit on a strip whose bad flag is set in that channel's calibration memory adds no charge. It acts as an empty strip, so hits on either side of it fall into separate clusters.
- R2: Corrected charge is floor((adc - ped) * gain / 16), where gain is unsigned with 4 fractional bits (16 means 1.0). A hit with adc at or below ped, or with a corrected charge of zero, counts as no hit.
- R3: A surviving hit whose address is exactly one above the previous surviving hit joins the open cluster. Any other address closes the open cluster and starts a new one.
- R4: A cluster holds at most 8 strips. A ninth consecutive hit starts a new cluster.
- R5: Each cluster output carries clu_charge equal to the sum of its corrected charges. clu_pos equals floor(4 * sum(addr * charge) / sum(charge)): the two low bits are quarter strips and the upper bits are the strip number. Cluster outputs have clu_eoe = 0 and a nonzero charge.
- R6: An accepted end-of-event marker flushes the open cluster. One cycle after that cluster's output, a marker output follows (clu_valid = 1, clu_eoe = 1, clu_pos = 0, clu_charge = 0). With no open cluster, only the marker is produced.
- R7: A hit is taken only in a cycle where hit_valid and hit_ready are both high. hit_ready is low in the cycle after an end-of-event marker or a cluster-closing hit is taken, and it stays low while the centroid division runs.
- R8: Channels run independently. A calibration write goes only to the channel that cfg_chan selects, and each channel's outputs depend only on its own inputs and its own calibration.
- R9: After reset, hit_ready is high and clu_valid is low on every channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Calibration write strobe |
| cfg_chan | input | 3 | Channel whose memory is written |
| cfg_strip | input | 7 | Strip address written |
| cfg_bad | input | 1 | Bad-strip flag |
| cfg_ped | input | 8 | Pedestal |
| cfg_gain | input | 8 | Gain, 4 fractional bits |
| hit_valid | input | 8 | Per-channel input valid |
| hit_eoe | input | 8 | Per-channel end-of-event marker |
| hit_strip | input | 56 | Per-channel strip address, 7 bits each |
| hit_adc | input | 64 | Per-channel raw ADC, 8 bits each |
| hit_ready | output | 8 | Per-channel input ready |
| clu_valid | output | 8 | Per-channel output valid |
| clu_eoe | output | 8 | Per-channel end-of-event marker out |
| clu_pos | output | 72 | Per-channel centroid, 9 bits each, 2 fractional |
| clu_charge | output | 120 | Per-channel summed charge, 15 bits each |

## Verification
The hardest case to reach from the ports is a cluster that is closed by its width limit rather than by a gap. It needs nine or more consecutive strips that all survive correction, fed in while the divider for the previous cluster stalls the input. The stimulus drives an eleven-strip run with uniform pedestal and gain. It then checks for one cluster of eight and one of three, each with its own centroid. A second hard case is a bad strip between two good neighbours. The bench programs the flag through the write port and expects two clusters.

// File: rtl/sclu_pkg.sv
package sclu_pkg;
    localparam int unsigned DEF_NCH       = 8;
    localparam int unsigned DEF_ADDR_W    = 7;
    localparam int unsigned DEF_ADC_W     = 8;
    localparam int unsigned DEF_GAIN_W    = 8;
    localparam int unsigned DEF_GAIN_FRAC = 4;
    localparam int unsigned DEF_MAX_W     = 8;
    localparam int unsigned DEF_FRAC      = 2;

    typedef enum logic [1:0] {
        DV_IDLE,
        DV_RUN,
        DV_MARK
    } div_phase_e;
endpackage

// File: rtl/strip_corr.sv
// Calibration lookup and pedestal/gain correction for one channel.
module strip_corr #(
    parameter int ADDR_W    = 7,
    parameter int ADC_W     = 8,
    parameter int GAIN_W    = 8,
    parameter int GAIN_FRAC = 4,
    parameter int Q_W       = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_strip,
    input  logic              cfg_bad,
    input  logic [ADC_W-1:0]  cfg_ped,
    input  logic [GAIN_W-1:0] cfg_gain,
    input  logic              take,
    input  logic              in_eoe,
    input  logic [ADDR_W-1:0] in_strip,
    input  logic [ADC_W-1:0]  in_adc,
    output logic              s_valid,
    output logic              s_eoe,
    output logic              s_hit,
    output logic [ADDR_W-1:0] s_strip,
    output logic [Q_W-1:0]    s_charge
);
    localparam int NSTRIP = 1 << ADDR_W;
    localparam int ENT_W  = 1 + ADC_W + GAIN_W;
    localparam int PROD_W = ADC_W + GAIN_W;

    typedef struct packed {
        logic              valid;
        logic              eoe;
        logic [ADDR_W-1:0] strip;
        logic [ADC_W-1:0]  adc;
    } stage_t;

    stage_t st_d, st_q;
    logic [ENT_W-1:0] lut_mem [NSTRIP];
    logic [ENT_W-1:0] ent_q;

    always_ff @(posedge clk) begin
        if (cfg_we) lut_mem[cfg_strip] <= {cfg_bad, cfg_ped, cfg_gain};
        if (take)   ent_q <= lut_mem[in_strip];
    end

    always_comb begin
        st_d       = st_q;
        st_d.valid = take;
        if (take) begin
            st_d.eoe   = in_eoe;
            st_d.strip = in_strip;
            st_d.adc   = in_adc;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    logic              ent_bad;
    logic [ADC_W-1:0]  ent_ped;
    logic [GAIN_W-1:0] ent_gain;
    logic [ADC_W-1:0]  excess;
    logic [PROD_W-1:0] prod;

    assign {ent_bad, ent_ped, ent_gain} = ent_q;

    always_comb begin
        excess = (st_q.adc > ent_ped) ? (st_q.adc - ent_ped) : '0;
        prod   = PROD_W'(excess) * PROD_W'(ent_gain);
    end

    assign s_charge = Q_W'(prod >> GAIN_FRAC);
    assign s_valid  = st_q.valid;
    assign s_eoe    = st_q.eoe;
    assign s_strip  = st_q.strip;
    assign s_hit    = st_q.valid && !st_q.eoe && !ent_bad && (s_charge != '0);
endmodule

// File: rtl/clus_group.sv
// Adjacency grouping and charge/moment accumulation for one channel.
module clus_group #(
    parameter int ADDR_W  = 7,
    parameter int Q_W     = 12,
    parameter int MAX_W   = 8,
    parameter int SUMQ_W  = 15,
    parameter int SUMQA_W = 22
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               s_valid,
    input  logic               s_eoe,
    input  logic               s_hit,
    input  logic [ADDR_W-1:0]  s_strip,
    input  logic [Q_W-1:0]     s_charge,
    output logic               stall,
    output logic               emit,
    output logic               emit_eoe,
    output logic               mark,
    output logic [SUMQ_W-1:0]  emit_sumq,
    output logic [SUMQA_W-1:0] emit_sumqa
);
    localparam int WID_W = $clog2(MAX_W + 1);

    typedef struct packed {
        logic               open;
        logic [ADDR_W-1:0]  last;
        logic [WID_W-1:0]   width;
        logic [SUMQ_W-1:0]  sumq;
        logic [SUMQA_W-1:0] sumqa;
    } grp_t;

    grp_t g_d, g_q;
    logic joins;

    always_comb begin
        g_d      = g_q;
        emit     = 1'b0;
        emit_eoe = 1'b0;
        mark     = 1'b0;
        joins    = g_q.open && (s_strip == ADDR_W'(g_q.last + 1'b1))
                   && (g_q.width < WID_W'(MAX_W));
        if (s_valid) begin
            if (s_eoe) begin
                if (g_q.open) begin
                    emit     = 1'b1;
                    emit_eoe = 1'b1;
                    g_d.open = 1'b0;
                end else begin
                    mark = 1'b1;
                end
            end else if (s_hit) begin
                if (joins) begin
                    g_d.width = g_q.width + 1'b1;
                    g_d.sumq  = g_q.sumq + SUMQ_W'(s_charge);
                    g_d.sumqa = g_q.sumqa + SUMQA_W'(s_charge) * SUMQA_W'(s_strip);
                end else begin
                    emit      = g_q.open;
                    g_d.open  = 1'b1;
                    g_d.width = WID_W'(1);
                    g_d.sumq  = SUMQ_W'(s_charge);
                    g_d.sumqa = SUMQA_W'(s_charge) * SUMQA_W'(s_strip);
                end
                g_d.last = s_strip;
            end
        end
    end

    assign stall      = emit || mark;
    assign emit_sumq  = g_q.sumq;
    assign emit_sumqa = g_q.sumqa;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end
endmodule

// File: rtl/cent_div.sv
// Sequential restoring divider: centroid = (moment << FRAC) / charge.
module cent_div
    import sclu_pkg::*;
#(
    parameter int SUMQ_W  = 15,
    parameter int SUMQA_W = 22,
    parameter int FRAC    = 2,
    parameter int POS_W   = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               start_eoe,
    input  logic               mark,
    input  logic [SUMQ_W-1:0]  sumq,
    input  logic [SUMQA_W-1:0] sumqa,
    output logic               busy,
    output logic               o_valid,
    output logic               o_eoe,
    output logic [POS_W-1:0]   o_pos,
    output logic [SUMQ_W-1:0]  o_chg
);
    localparam int NUM_W = SUMQA_W + FRAC;
    localparam int CNT_W = $clog2(NUM_W);

    typedef struct packed {
        div_phase_e        phase;
        logic [CNT_W-1:0]  cnt;
        logic [NUM_W-1:0]  num;
        logic [SUMQ_W-1:0] rem;
        logic [POS_W-1:0]  quo;
        logic [SUMQ_W-1:0] den;
        logic              eoe_pend;
        logic              valid;
        logic              eoe;
        logic [POS_W-1:0]  pos;
        logic [SUMQ_W-1:0] chg;
    } div_t;

    div_t d_d, d_q;
    logic [SUMQ_W:0] trial;
    logic            q_bit;

    always_comb begin
        d_d       = d_q;
        d_d.valid = 1'b0;
        d_d.eoe   = 1'b0;
        d_d.pos   = '0;
        d_d.chg   = '0;
        trial     = {d_q.rem, d_q.num[NUM_W-1]};
        q_bit     = 1'b0;
        case (d_q.phase)
            DV_IDLE: begin
                if (start) begin
                    d_d.phase    = DV_RUN;
                    d_d.cnt      = '0;
                    d_d.num      = {sumqa, {FRAC{1'b0}}};
                    d_d.rem      = '0;
                    d_d.quo      = '0;
                    d_d.den      = sumq;
                    d_d.eoe_pend = start_eoe;
                end else if (mark) begin
                    d_d.valid = 1'b1;
                    d_d.eoe   = 1'b1;
                end
            end
            DV_RUN: begin
                d_d.num = d_q.num << 1;
                if (trial >= {1'b0, d_q.den}) begin
                    q_bit   = 1'b1;
                    d_d.rem = SUMQ_W'(trial - {1'b0, d_q.den});
                end else begin
                    d_d.rem = trial[SUMQ_W-1:0];
                end
                d_d.quo = {d_q.quo[POS_W-2:0], q_bit};
                d_d.cnt = d_q.cnt + 1'b1;
                if (d_q.cnt == CNT_W'(NUM_W - 1)) begin
                    d_d.valid = 1'b1;
                    d_d.pos   = {d_q.quo[POS_W-2:0], q_bit};
                    d_d.chg   = d_q.den;
                    d_d.phase = d_q.eoe_pend ? DV_MARK : DV_IDLE;
                end
            end
            DV_MARK: begin
                d_d.valid = 1'b1;
                d_d.eoe   = 1'b1;
                d_d.phase = DV_IDLE;
            end
            default: d_d.phase = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) d_q <= '0;
        else        d_q <= d_d;
    end

    assign busy    = (d_q.phase != DV_IDLE);
    assign o_valid = d_q.valid;
    assign o_eoe   = d_q.eoe;
    assign o_pos   = d_q.pos;
    assign o_chg   = d_q.chg;
endmodule

// File: rtl/strip_clusterer.sv
module strip_clusterer
    import sclu_pkg::*;
#(
    parameter int NCH       = DEF_NCH,
    parameter int ADDR_W    = DEF_ADDR_W,
    parameter int ADC_W     = DEF_ADC_W,
    parameter int GAIN_W    = DEF_GAIN_W,
    parameter int GAIN_FRAC = DEF_GAIN_FRAC,
    parameter int MAX_W     = DEF_MAX_W,
    parameter int FRAC      = DEF_FRAC,
    parameter int CH_W      = (NCH > 1) ? $clog2(NCH) : 1,
    parameter int Q_W       = ADC_W + GAIN_W - GAIN_FRAC,
    parameter int SUMQ_W    = Q_W + $clog2(MAX_W),
    parameter int SUMQA_W   = SUMQ_W + ADDR_W,
    parameter int POS_W     = ADDR_W + FRAC
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cfg_we,
    input  logic [CH_W-1:0]         cfg_chan,
    input  logic [ADDR_W-1:0]       cfg_strip,
    input  logic                    cfg_bad,
    input  logic [ADC_W-1:0]        cfg_ped,
    input  logic [GAIN_W-1:0]       cfg_gain,
    input  logic [NCH-1:0]          hit_valid,
    input  logic [NCH-1:0]          hit_eoe,
    input  logic [NCH*ADDR_W-1:0]   hit_strip,
    input  logic [NCH*ADC_W-1:0]    hit_adc,
    output logic [NCH-1:0]          hit_ready,
    output logic [NCH-1:0]          clu_valid,
    output logic [NCH-1:0]          clu_eoe,
    output logic [NCH*POS_W-1:0]    clu_pos,
    output logic [NCH*SUMQ_W-1:0]   clu_charge
);
    for (genvar c = 0; c < NCH; c++) begin : g_ch
        logic               take, we_c;
        logic               s_valid, s_eoe, s_hit;
        logic [ADDR_W-1:0]  s_strip;
        logic [Q_W-1:0]     s_charge;
        logic               stall, emit, emit_eoe, mark, busy;
        logic [SUMQ_W-1:0]  emit_sumq;
        logic [SUMQA_W-1:0] emit_sumqa;

        assign we_c         = cfg_we && (cfg_chan == CH_W'(c));
        assign hit_ready[c] = !busy && !stall;
        assign take         = hit_valid[c] && hit_ready[c];

        strip_corr #(
            .ADDR_W(ADDR_W), .ADC_W(ADC_W), .GAIN_W(GAIN_W),
            .GAIN_FRAC(GAIN_FRAC), .Q_W(Q_W)
        ) u_corr (
            .clk(clk), .rst_n(rst_n),
            .cfg_we(we_c), .cfg_strip(cfg_strip), .cfg_bad(cfg_bad),
            .cfg_ped(cfg_ped), .cfg_gain(cfg_gain),
            .take(take), .in_eoe(hit_eoe[c]),
            .in_strip(hit_strip[c*ADDR_W +: ADDR_W]),
            .in_adc(hit_adc[c*ADC_W +: ADC_W]),
            .s_valid(s_valid), .s_eoe(s_eoe), .s_hit(s_hit),
            .s_strip(s_strip), .s_charge(s_charge)
        );

        clus_group #(
            .ADDR_W(ADDR_W), .Q_W(Q_W), .MAX_W(MAX_W),
            .SUMQ_W(SUMQ_W), .SUMQA_W(SUMQA_W)
        ) u_grp (
            .clk(clk), .rst_n(rst_n),
            .s_valid(s_valid), .s_eoe(s_eoe), .s_hit(s_hit),
            .s_strip(s_strip), .s_charge(s_charge),
            .stall(stall), .emit(emit), .emit_eoe(emit_eoe), .mark(mark),
            .emit_sumq(emit_sumq), .emit_sumqa(emit_sumqa)
        );

        cent_div #(
            .SUMQ_W(SUMQ_W), .SUMQA_W(SUMQA_W), .FRAC(FRAC), .POS_W(POS_W)
        ) u_div (
            .clk(clk), .rst_n(rst_n),
            .start(emit), .start_eoe(emit_eoe), .mark(mark),
            .sumq(emit_sumq), .sumqa(emit_sumqa),
            .busy(busy),
            .o_valid(clu_valid[c]), .o_eoe(clu_eoe[c]),
            .o_pos(clu_pos[c*POS_W +: POS_W]),
            .o_chg(clu_charge[c*SUMQ_W +: SUMQ_W])
        );
    end
endmodule

// File: rtl/sclu_chk.sv
module sclu_chk #(
    parameter int NCH    = 8,
    parameter int Q_W    = 12,
    parameter int MAX_W  = 8,
    parameter int SUMQ_W = 15,
    parameter int POS_W  = 9
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [NCH-1:0]        hit_valid,
    input logic [NCH-1:0]        hit_eoe,
    input logic [NCH-1:0]        hit_ready,
    input logic [NCH-1:0]        clu_valid,
    input logic [NCH-1:0]        clu_eoe,
    input logic [NCH*POS_W-1:0]  clu_pos,
    input logic [NCH*SUMQ_W-1:0] clu_charge
);
    localparam int CAP = MAX_W * ((1 << Q_W) - 1);

    for (genvar c = 0; c < NCH; c++) begin : g_chk
        // R6
        marker_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clu_valid[c] && clu_eoe[c]) |->
            (clu_pos[c*POS_W +: POS_W] == '0 && clu_charge[c*SUMQ_W +: SUMQ_W] == '0));

        // R5
        cluster_charge_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clu_valid[c] && !clu_eoe[c]) |-> (clu_charge[c*SUMQ_W +: SUMQ_W] != '0));

        // R4
        width_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clu_valid[c] |-> (int'(clu_charge[c*SUMQ_W +: SUMQ_W]) <= CAP));

        // R7
        eoe_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (hit_valid[c] && hit_ready[c] && hit_eoe[c]) |=> !hit_ready[c]);

        // R7
        div_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (clu_valid[c] && !clu_eoe[c]) |=> !(clu_valid[c] && !clu_eoe[c]));
    end
endmodule

bind strip_clusterer sclu_chk #(
    .NCH(NCH), .Q_W(Q_W), .MAX_W(MAX_W), .SUMQ_W(SUMQ_W), .POS_W(POS_W)
) u_sclu_chk (
    .clk(clk), .rst_n(rst_n), .hit_valid(hit_valid), .hit_eoe(hit_eoe),
    .hit_ready(hit_ready), .clu_valid(clu_valid), .clu_eoe(clu_eoe),
    .clu_pos(clu_pos), .clu_charge(clu_charge)
);

// File: tb/tb_strip_clusterer.sv
`timescale 1ns/1ps
module tb_strip_clusterer;
    localparam int NCH = 8, ADDR_W = 7, ADC_W = 8, GAIN_W = 8;
    localparam int CH_W = 3, POS_W = 9, SUMQ_W = 15;
    localparam int NSTRIP = 1 << ADDR_W;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cfg_we = 1'b0, cfg_bad = 1'b0;
    logic [CH_W-1:0] cfg_chan = '0;
    logic [ADDR_W-1:0] cfg_strip = '0;
    logic [ADC_W-1:0] cfg_ped = '0;
    logic [GAIN_W-1:0] cfg_gain = '0;
    logic [NCH-1:0] hit_valid = '0, hit_eoe = '0;
    logic [NCH*ADDR_W-1:0] hit_strip = '0;
    logic [NCH*ADC_W-1:0] hit_adc = '0;
    logic [NCH-1:0] hit_ready, clu_valid, clu_eoe;
    logic [NCH*POS_W-1:0] clu_pos;
    logic [NCH*SUMQ_W-1:0] clu_charge;

    always #2.5 clk = ~clk;

    strip_clusterer dut (.*);

    int checks = 0, failures = 0;
    bit tb_bad [NCH][NSTRIP];
    int tb_ped [NCH][NSTRIP];
    int tb_gain [NCH][NSTRIP];
    int ev_n [NCH];
    int ev_strip [NCH][32];
    int ev_adc [NCH][32];
    int got_n [NCH];
    int got_pos [NCH][32];
    int got_chg [NCH][32];
    bit got_eoe [NCH][32];
    int exp_n;
    int exp_pos [32];
    int exp_chg [32];
    bit exp_eoe [32];

    always @(negedge clk) begin
        if (rst_n) begin
            for (int c = 0; c < NCH; c++) begin
                if (clu_valid[c] && got_n[c] < 32) begin
                    got_pos[c][got_n[c]] = int'(clu_pos[c*POS_W +: POS_W]);
                    got_chg[c][got_n[c]] = int'(clu_charge[c*SUMQ_W +: SUMQ_W]);
                    got_eoe[c][got_n[c]] = clu_eoe[c];
                    got_n[c]++;
                end
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
        end
    endtask

    task automatic cfg_write(input int ch, input int strip, input bit bad,
                             input int ped, input int gain);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = CH_W'(ch); cfg_strip = ADDR_W'(strip);
        cfg_bad = bad; cfg_ped = ADC_W'(ped); cfg_gain = GAIN_W'(gain);
        tb_bad[ch][strip] = bad; tb_ped[ch][strip] = ped; tb_gain[ch][strip] = gain;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic send(input int ch, input bit eoe, input int strip, input int adc);
        @(negedge clk);
        while (!hit_ready[ch]) @(negedge clk);
        hit_valid[ch] = 1'b1; hit_eoe[ch] = eoe;
        hit_strip[ch*ADDR_W +: ADDR_W] = ADDR_W'(strip);
        hit_adc[ch*ADC_W +: ADC_W] = ADC_W'(adc);
        @(negedge clk);
        hit_valid[ch] = 1'b0; hit_eoe[ch] = 1'b0;
    endtask

    task automatic add_hit(input int ch, input int strip, input int adc);
        ev_strip[ch][ev_n[ch]] = strip;
        ev_adc[ch][ev_n[ch]] = adc;
        ev_n[ch]++;
    endtask

    // Expected clusters from R1..R6, computed from the bench's own calibration copy.
    task automatic build_expect(input int ch);
        bit open = 0; int last = 0, w = 0, sq = 0, sqa = 0;
        exp_n = 0;
        for (int i = 0; i < ev_n[ch]; i++) begin
            int s = ev_strip[ch][i];
            int a = ev_adc[ch][i];
            int q = (a > tb_ped[ch][s]) ? ((a - tb_ped[ch][s]) * tb_gain[ch][s]) / 16 : 0;
            if (!tb_bad[ch][s] && q != 0) begin
                if (open && s == last + 1 && w < 8) begin
                    w++; sq += q; sqa += q * s;
                end else begin
                    if (open) begin
                        exp_pos[exp_n] = (sqa * 4) / sq; exp_chg[exp_n] = sq;
                        exp_eoe[exp_n] = 0; exp_n++;
                    end
                    open = 1; w = 1; sq = q; sqa = q * s;
                end
                last = s;
            end
        end
        if (open) begin
            exp_pos[exp_n] = (sqa * 4) / sq; exp_chg[exp_n] = sq;
            exp_eoe[exp_n] = 0; exp_n++;
        end
        exp_pos[exp_n] = 0; exp_chg[exp_n] = 0; exp_eoe[exp_n] = 1; exp_n++;
    endtask

    task automatic drive_event(input int ch);
        for (int i = 0; i < ev_n[ch]; i++) send(ch, 1'b0, ev_strip[ch][i], ev_adc[ch][i]);
        send(ch, 1'b1, 0, 0);
    endtask

    task automatic wait_marker(input int ch, input string tag);
        int t = 0;
        while (!(got_n[ch] > 0 && got_eoe[ch][got_n[ch]-1]) && t < 3000) begin
            @(negedge clk); t++;
        end
        chk(t < 3000, tag, "marker timeout", t, 3000);
    endtask

    task automatic compare(input int ch, input string tag);
        build_expect(ch);
        chk(got_n[ch] == exp_n, tag, "record count", got_n[ch], exp_n);
        for (int i = 0; i < exp_n && i < got_n[ch]; i++) begin
            chk(got_eoe[ch][i] == exp_eoe[i], tag, $sformatf("rec%0d eoe", i),
                int'(got_eoe[ch][i]), int'(exp_eoe[i]));
            chk(got_pos[ch][i] == exp_pos[i], tag, $sformatf("rec%0d pos", i),
                got_pos[ch][i], exp_pos[i]);
            chk(got_chg[ch][i] == exp_chg[i], tag, $sformatf("rec%0d charge", i),
                got_chg[ch][i], exp_chg[i]);
        end
    endtask

    task automatic run_event(input int ch, input string tag);
        got_n[ch] = 0;
        drive_event(ch);
        wait_marker(ch, tag);
        compare(ch, tag);
        ev_n[ch] = 0;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(hit_ready == '1, "R9", "hit_ready after reset", int'(hit_ready), 255);
        chk(clu_valid == '0, "R9", "clu_valid after reset", int'(clu_valid), 0);
    endtask

    task automatic t_isolated();
        cfg_write(0, 3, 0, 20, 24);    // R2: (50-20)*24/16 = 45
        cfg_write(0, 10, 0, 5, 16);
        add_hit(0, 3, 50);
        add_hit(0, 10, 200);
        run_event(0, "R2");
    endtask

    task automatic t_adjacent();
        add_hit(0, 30, 26); add_hit(0, 31, 58); add_hit(0, 32, 14);   // R3 R5
        add_hit(0, 34, 40);
        run_event(0, "R3");
    endtask

    task automatic t_bad_strip();
        cfg_write(0, 21, 1, 10, 16);   // R1
        add_hit(0, 20, 40); add_hit(0, 21, 250); add_hit(0, 22, 40);
        run_event(0, "R1");
    endtask

    task automatic t_below_ped();
        cfg_write(0, 45, 0, 10, 1);    // (11-10)*1/16 = 0: no hit
        add_hit(0, 44, 30); add_hit(0, 45, 5); add_hit(0, 46, 30);     // R2
        add_hit(0, 50, 30); add_hit(0, 51, 10); add_hit(0, 52, 30);
        run_event(0, "R2");
        add_hit(0, 44, 30); add_hit(0, 45, 11); add_hit(0, 46, 30);
        run_event(0, "R2");
    endtask

    task automatic t_width_cap();
        for (int s = 60; s <= 70; s++) add_hit(1, s, 20 + s - 60);    // R4
        run_event(1, "R4");
    endtask

    task automatic t_empty_eoe();
        run_event(3, "R6");            // R6: marker only
        add_hit(3, 90, 100);
        run_event(3, "R6");
    endtask

    task automatic t_ready();
        got_n[4] = 0;
        send(4, 1'b0, 40, 60);
        send(4, 1'b0, 50, 60);         // closes the cluster at 40
        chk(hit_ready[4] == 1'b0, "R7", "ready after closing hit", int'(hit_ready[4]), 0);
        repeat (5) @(negedge clk);
        chk(hit_ready[4] == 1'b0, "R7", "ready during division", int'(hit_ready[4]), 0);
        send(4, 1'b1, 0, 0);
        chk(hit_ready[4] == 1'b0, "R7", "ready after eoe", int'(hit_ready[4]), 0);
        wait_marker(4, "R7");
        chk(got_n[4] == 3, "R7", "record count", got_n[4], 3);
        chk(got_pos[4][0] == 160, "R7", "first centroid", got_pos[4][0], 160);
        chk(got_pos[4][1] == 200, "R7", "second centroid", got_pos[4][1], 200);
    endtask

    task automatic t_channels();
        cfg_write(5, 70, 0, 10, 32);   // R8: only channel 5 doubles strip 70
        got_n[0] = 0;
        add_hit(2, 70, 50); add_hit(2, 71, 50);
        add_hit(5, 70, 50); add_hit(5, 71, 50);
        got_n[2] = 0; got_n[5] = 0;
        fork
            drive_event(2);
            drive_event(5);
        join
        wait_marker(2, "R8");
        wait_marker(5, "R8");
        compare(2, "R8");
        compare(5, "R8");
        chk(got_n[0] == 0, "R8", "idle channel output", got_n[0], 0);
        ev_n[2] = 0; ev_n[5] = 0;
    endtask

    initial begin
        int cyc = 0;
        while (cyc < 150000) begin
            @(posedge clk); cyc++;
        end
        chk(1'b0, "WD", "watchdog expired", cyc, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int c = 0; c < NCH; c++) begin ev_n[c] = 0; got_n[c] = 0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        for (int c = 0; c < NCH; c++)
            for (int s = 0; s < NSTRIP; s++) cfg_write(c, s, 0, 10, 16);
        t_isolated();
        t_adjacent();
        t_bad_strip();
        t_below_ped();
        t_width_cap();
        t_empty_eoe();
        t_ready();
        t_channels();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule